// File: doc/BRIEF.md
# Predicated Pairwise Widening Add-Accumulate Unit

This block is one SIMD execution datapath. It treats a vector register of `VW` bits as a row of equal lanes. A two-bit size code picks the lane width: 16, 32 or 64 bits. For each lane, the matching lane of the source operand is cut into a lower half and an upper half. Each half is extended to the full lane width, with sign extension or zero extension. Both halves are added to the accumulator lane, and the sum wraps modulo the lane width.

A predicate with one bit per vector byte chooses which lanes take the new value. A lane with its predicate bit clear passes its accumulator value through unchanged. All lanes are computed together in one cycle, and the result is registered.

A request is illegal in three cases: the size code asks for 8-bit lanes, the opcode field is neither the signed nor the unsigned form, or the extended vector feature is off. An illegal request raises a flag beside the result and returns the accumulator untouched.

Top module: `pwacc_unit`

## Requirements
- R1: Size code 1, 2 and 3 select lane widths of 16, 32 and 64 bits. Lane i of width W covers bits [i*W+W-1 : i*W] of every vector operand. Its source lane splits into a low half (lower W/2 bits) and a high half (upper W/2 bits).
- R2: Opcode 3'b100 is the signed form: both halves are sign-extended to W bits before the add.
- R3: Opcode 3'b101 is the unsigned form: both halves are zero-extended to W bits before the add.
- R4: The lane result is accumulator + low + high, truncated to W bits. The sum wraps with no saturation and no carry into the neighbouring lane.
- R5: Lane i uses predicate bit i*W/8, the bit of its least significant byte. When that bit is 0, the lane result equals the accumulator lane. Every other predicate bit is ignored.
- R6: Size code 0 is illegal. The result equals the accumulator input and the illegal flag is set.
- R7: With `feat_en` low, every request is illegal, with the result equal to the accumulator input.
- R8: Any opcode other than 3'b100 and 3'b101 is illegal, with the result equal to the accumulator input.
- R9: `out_valid` is `in_valid` delayed by exactly one cycle. `out_illegal` belongs to that same output cycle and is only ever high together with `out_valid`.
- R10: After reset, `out_valid`, `out_illegal` and `res_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| feat_en | input | 1 | Extended vector feature enable |
| opc | input | 3 | Operation field, 100 signed, 101 unsigned |
| size_code | input | 2 | Lane width code, 1/2/3 for 16/32/64 bits |
| acc_in | input | VW | Accumulator vector |
| src_in | input | VW | Source vector |
| pred_in | input | VW/8 | Predicate, one bit per byte |
| out_valid | output | 1 | Result strobe |
| out_illegal | output | 1 | Request was rejected |
| res_out | output | VW | Result vector |

## Verification
The assertions assume that `VW` is a multiple of 64. They also assume that the request inputs are sampled at the clock edge where `in_valid` is high, since their checks refer to `$past` of the inputs from that cycle. The bench changes inputs only on falling edges. It holds each request for exactly one cycle and then drops `in_valid`. This keeps every assertion window aligned with one request. The sweep covers every legal size, both signedness forms, random and extreme operands, and sparse predicates. It also sends each of the three illegal triggers separately.

// File: rtl/pwacc_unit.sv
module pwacc_unit #(
  parameter int VW = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            feat_en,
  input  logic [2:0]      opc,
  input  logic [1:0]      size_code,
  input  logic [VW-1:0]   acc_in,
  input  logic [VW-1:0]   src_in,
  input  logic [VW/8-1:0] pred_in,
  output logic            out_valid,
  output logic            out_illegal,
  output logic [VW-1:0]   res_out
);
  localparam int NSZ = 3;

  logic              sgn, bad;
  logic [NSZ-1:0][VW-1:0] per_sz;
  logic [VW-1:0]     nxt;

  assign sgn = ~opc[0];
  assign bad = !feat_en || (size_code == 2'd0) || (opc[2:1] != 2'b10);

  for (genvar k = 0; k < NSZ; k++) begin : g_sz
    localparam int W = 16 << k;
    localparam int H = W / 2;
    for (genvar i = 0; i < VW / W; i++) begin : g_ln
      logic [H-1:0] lo, hi;
      logic [W-1:0] a, r;
      assign lo = src_in[i*W +: H];
      assign hi = src_in[i*W+H +: H];
      assign a  = acc_in[i*W +: W];
      assign r  = a + {{H{sgn & lo[H-1]}}, lo} + {{H{sgn & hi[H-1]}}, hi};
      assign per_sz[k][i*W +: W] = pred_in[i*W/8] ? r : a;
    end
  end

  always_comb begin
    case (size_code)
      2'd1:    nxt = per_sz[0];
      2'd2:    nxt = per_sz[1];
      2'd3:    nxt = per_sz[2];
      default: nxt = acc_in;
    endcase
    if (bad) nxt = acc_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      res_out     <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid & bad;
      if (in_valid) res_out <= nxt;
    end
  end
endmodule

// File: rtl/pwacc_unit_chk.sv
module pwacc_unit_chk #(
  parameter int VW = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            feat_en,
  input logic [2:0]      opc,
  input logic [1:0]      size_code,
  input logic [VW-1:0]   acc_in,
  input logic [VW-1:0]   src_in,
  input logic [VW/8-1:0] pred_in,
  input logic            out_valid,
  input logic            out_illegal,
  input logic [VW-1:0]   res_out
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R9
  AST_ILL_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_valid); // R9
  AST_SIZE0_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && size_code == 2'd0 |=> out_illegal && res_out == $past(acc_in)); // R6
  AST_FEAT_OFF_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !feat_en |=> out_illegal && res_out == $past(acc_in)); // R7
  AST_BAD_OPC_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opc[2:1] != 2'b10 |=> out_illegal && res_out == $past(acc_in)); // R8
  AST_NO_PRED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && pred_in == '0 |=> res_out == $past(acc_in)); // R5
  AST_LEGAL_NOT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && feat_en && size_code != 2'd0 && opc[2:1] == 2'b10 |=> !out_illegal); // R6
endmodule

bind pwacc_unit pwacc_unit_chk #(.VW(VW)) u_chk (.*);

// File: tb/sim_pwacc_unit.sv
`timescale 1ns/1ps
module sim_pwacc_unit;
  localparam int VW = 128;
  localparam int PW = VW / 8;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, feat_en = 1'b1;
  logic [2:0] opc = 3'b100;
  logic [1:0] size_code = 2'd1;
  logic [VW-1:0] acc_in = '0, src_in = '0;
  logic [PW-1:0] pred_in = '0;
  logic out_valid, out_illegal;
  logic [VW-1:0] res_out;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwacc_unit #(.VW(VW)) u0 (.*);

  function automatic logic [VW-1:0] model(logic [VW-1:0] a, logic [VW-1:0] s,
      logic [PW-1:0] p, logic [1:0] sz, logic [2:0] op, logic fe);
    logic [VW-1:0] r;
    int w2, w;
    logic sg;
    r = a;
    if (!fe || sz == 0 || op[2:1] != 2'b10) return r;
    sg = ~op[0];
    w2 = 8 << sz;
    w = w2 / 2;
    for (int i = 0; i < VW / w2; i++) begin
      logic [63:0] aa, lo, hi, sm;
      int base;
      base = i * w2;
      aa = '0; lo = '0; hi = '0;
      for (int b = 0; b < w2; b++) aa[b] = a[base + b];
      for (int b = 0; b < w; b++) begin
        lo[b] = s[base + b];
        hi[b] = s[base + w + b];
      end
      for (int b = w; b < 64; b++) begin
        lo[b] = sg & lo[w-1];
        hi[b] = sg & hi[w-1];
      end
      sm = aa + lo + hi;
      if (p[base / 8])
        for (int b = 0; b < w2; b++) r[base + b] = sm[b];
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(string tag, logic fe, logic [2:0] op, logic [1:0] sz,
      logic [VW-1:0] a, logic [VW-1:0] s, logic [PW-1:0] p);
    logic [VW-1:0] exp;
    logic ill;
    exp = model(a, s, p, sz, op, fe);
    ill = !fe || sz == 0 || op[2:1] != 2'b10;
    @(negedge clk);
    feat_en = fe; opc = op; size_code = sz; acc_in = a; src_in = s; pred_in = p;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R9 valid"}, {127'd0, out_valid}, 128'd1);
    chk({tag, " R9 illegal"}, {127'd0, out_illegal}, {127'd0, ill});
    chk(tag, res_out, exp);
    @(negedge clk);
    chk({tag, " R9 valid drop"}, {126'd0, out_valid, out_illegal}, 128'd0);
  endtask

  function automatic logic [VW-1:0] rv();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    chk("R10 res", res_out, '0);
    chk("R10 flags", {126'd0, out_valid, out_illegal}, '0);
    rst_n = 1'b1;
    for (int sz = 1; sz <= 3; sz++)
      for (int op = 4; op <= 5; op++) begin
        string t;
        t = (op == 4) ? "R1 R2 R4 signed" : "R1 R3 R4 unsigned";
        for (int n = 0; n < 30; n++)
          run(t, 1'b1, 3'(op), 2'(sz), rv(), rv(), '1);
        for (int n = 0; n < 15; n++)
          run("R5 pred", 1'b1, 3'(op), 2'(sz), rv(), rv(), PW'($urandom));
        run("R4 wrap ones", 1'b1, 3'(op), 2'(sz), '1, '1, '1);
        run("R4 wrap max", 1'b1, 3'(op), 2'(sz), '1, {(VW/8){8'h7f}}, '1);
        run("R2 R3 min", 1'b1, 3'(op), 2'(sz), '0, {(VW/8){8'h80}}, '1);
        run("R5 no pred", 1'b1, 3'(op), 2'(sz), rv(), rv(), '0);
        run("R5 odd pred only", 1'b1, 3'(op), 2'(sz), rv(), rv(), {(PW/2){2'b10}});
      end
    for (int n = 0; n < 6; n++) begin
      run("R6 size0", 1'b1, 3'(4 + n % 2), 2'd0, rv(), rv(), '1);
      run("R7 feat off", 1'b0, 3'(4 + n % 2), 2'(1 + n % 3), rv(), rv(), '1);
    end
    for (int op = 0; op < 8; op++)
      if (op != 4 && op != 5)
        run("R8 bad opc", 1'b1, 3'(op), 2'd2, rv(), rv(), '1);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog R9 actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end
endmodule